// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an internal single-word request port and an external asynchronous static RAM of 32K words by 8 bits. A requester presents an address, a direction flag and, for writes, a data byte, with a valid/ready handshake. The controller turns each accepted request into a sequence of registered strobe levels on the RAM pins: active-low chip enable, write enable and output enable, a 15-bit address, an 8-bit outbound data bus with its own driver enable, and an 8-bit inbound data bus. Completion is signalled by a one-cycle done pulse. For reads, the captured byte appears at the same time and stays there.

All RAM timing limits are given as picosecond parameters together with the clock period. Each limit becomes a cycle count, computed as the ceiling of the limit over the period with a floor of one cycle. The read phase lasts long enough for both address access and read cycle time. A write has an address setup phase with write enable high, then a write pulse wide enough for pulse width, data setup, address-to-end-of-write and write cycle time. Output enable is held high for the whole write, so the RAM never drives the bus while the controller does. The controller drives the bus only during the write pulse. After every access a recovery phase with all strobes high lasts at least the RAM's output turn-off time.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, chip enable, write enable and output enable are high (1), the data driver enable is 0, ready is 1 and done is 0.
- R2: A read accepted at a clock edge drives chip enable and output enable low with write enable high for exactly RD_CYC cycles, where RD_CYC is the larger of ceil(access time / period) and ceil(read cycle time / period), each at least 1. The bus value seen at the last of those cycles appears on the read data output together with done.
- R3: A write accepted at a clock edge first drives chip enable low with write enable high for SU_CYC cycles (ceil of address setup over period, at least 1). It then drives write enable low for PW_CYC cycles, where PW_CYC is the largest of the pulse-width, data-setup and (address-to-end-of-write or write-cycle minus SU_CYC) counts. Write enable is low only while chip enable is low.
- R4: Output enable is high in every cycle in which write enable is low or the data driver enable is 1, so the RAM and the controller never drive the bus at the same time.
- R5: The data driver enable is 1 exactly in the cycles where write enable is low, and it carries the accepted write byte. The RAM address holds the accepted address, unchanged, for as long as chip enable stays low.
- R6: After each access all three strobes stay high for at least REC_CYC cycles (ceil of output turn-off time over period, at least 1), during which ready is 0. With a request waiting, chip enable falls again after exactly REC_CYC + 1 cycles high.
- R7: Ready is 1 only when no access is in progress. Changes of the request inputs while ready is 0 do not affect the access in progress, and no access starts from them.
- R8: Done is a one-cycle pulse that ends each read and each write. The read data output changes only when a read completes and keeps its value across later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (15) | Word address |
| req_wdata | input | DATA_W (8) | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (8) | Byte captured by the last read |
| sram_addr | output | ADDR_W (15) | RAM address pins |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_out | output | DATA_W (8) | Outbound data toward the RAM |
| sram_dq_oe | output | 1 | Driver enable for sram_dq_out |
| sram_dq_in | input | DATA_W (8) | Inbound data from the RAM bus |

## Verification
Take the clock edge that accepts a request as edge 0. With the default timing, the strobes change after edge 0. A read's done and data are due after edge RD_CYC (2), and a write's done after edge SU_CYC + PW_CYC (2). Ready returns REC_CYC (1) edges after done. The directed tasks step on falling edges and count that many steps before each comparison, so each sample falls in the middle of the cycle where the value is due. A behavioural RAM in the bench decodes the strobes. A monitor flags any cycle in which the RAM and the controller drive the bus together.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_WSU  = 3'd2,
      ST_WPL  = 3'd3,
      ST_REC  = 3'd4
   } seq_state_t;

   // ceiling of a picosecond limit over the clock period, never below one cycle
   function automatic int unsigned ps_to_cyc(input int unsigned lim_ps,
                                             input int unsigned per_ps);
      int unsigned r;
      r = (lim_ps + per_ps - 1) / per_ps;
      if (r < 1) r = 1;
      return r;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // subtraction that stops at zero
   function automatic int unsigned sub_floor(input int unsigned a, input int unsigned b);
      return (a > b) ? (a - b) : 0;
   endfunction

endpackage

// File: rtl/asram_dly_cnt.sv
module asram_dly_cnt #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int unsigned RD_CYC  = 2,
   parameter int unsigned SU_CYC  = 1,
   parameter int unsigned PW_CYC  = 1,
   parameter int unsigned REC_CYC = 1,
   parameter int unsigned CNT_W   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_we,
   output logic       req_ready,
   output logic       accept,
   output logic       rd_last,
   output logic       wr_last,
   output seq_state_t nxt_state
);

   localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] SU_LD  = CNT_W'(SU_CYC - 1);
   localparam logic [CNT_W-1:0] PW_LD  = CNT_W'(PW_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

   seq_state_t       state_q;
   logic             expired;
   logic             ld;
   logic [CNT_W-1:0] ld_val;

   asram_dly_cnt #(.CNT_W(CNT_W)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .expired  (expired)
   );

   always_comb begin
      nxt_state = state_q;
      unique case (state_q)
         ST_IDLE: if (req_valid) nxt_state = req_we ? ST_WSU : ST_RD;
         ST_RD:   if (expired)   nxt_state = ST_REC;
         ST_WSU:  if (expired)   nxt_state = ST_WPL;
         ST_WPL:  if (expired)   nxt_state = ST_REC;
         ST_REC:  if (expired)   nxt_state = ST_IDLE;
         default:                nxt_state = ST_IDLE;
      endcase
   end

   // reload the phase counter on every entry into a timed phase
   always_comb begin
      ld     = (nxt_state != state_q) && (nxt_state != ST_IDLE);
      ld_val = '0;
      unique case (nxt_state)
         ST_RD:   ld_val = RD_LD;
         ST_WSU:  ld_val = SU_LD;
         ST_WPL:  ld_val = PW_LD;
         ST_REC:  ld_val = REC_LD;
         default: ld_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= nxt_state;
   end

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign rd_last   = (state_q == ST_RD)  && expired;
   assign wr_last   = (state_q == ST_WPL) && expired;

endmodule

// File: rtl/asram_io.sv
module asram_io
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_t        nxt_state,
   input  logic              accept,
   input  logic              rd_last,
   input  logic              wr_last,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] sram_dq_in,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata
);

   logic sel_nxt;
   assign sel_nxt = (nxt_state == ST_RD) || (nxt_state == ST_WSU) || (nxt_state == ST_WPL);

   // strobes come straight from flops so no decode glitch reaches the RAM
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sram_ce_n  <= 1'b1;
         sram_oe_n  <= 1'b1;
         sram_we_n  <= 1'b1;
         sram_dq_oe <= 1'b0;
      end else begin
         sram_ce_n  <= !sel_nxt;
         sram_oe_n  <= (nxt_state != ST_RD);
         sram_we_n  <= (nxt_state != ST_WPL);
         sram_dq_oe <= (nxt_state == ST_WPL);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sram_addr   <= '0;
         sram_dq_out <= '0;
      end else if (accept) begin
         sram_addr   <= req_addr;
         sram_dq_out <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_done  <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_done <= rd_last || wr_last;
         if (rd_last) rsp_rdata <= sram_dq_in;
      end
   end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W   = 15,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CLK_PS   = 10000,
   parameter int unsigned T_AA_PS  = 12000,
   parameter int unsigned T_RC_PS  = 12000,
   parameter int unsigned T_WC_PS  = 12000,
   parameter int unsigned T_AS_PS  = 0,
   parameter int unsigned T_AW_PS  = 10000,
   parameter int unsigned T_WP_PS  = 10000,
   parameter int unsigned T_DW_PS  = 6000,
   parameter int unsigned T_HZ_PS  = 6000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_in
);

   localparam int unsigned RD_CYC  = max_u(ps_to_cyc(T_AA_PS, CLK_PS),
                                           ps_to_cyc(T_RC_PS, CLK_PS));
   localparam int unsigned SU_CYC  = ps_to_cyc(T_AS_PS, CLK_PS);
   localparam int unsigned WIN_CYC = max_u(ps_to_cyc(T_AW_PS, CLK_PS),
                                           ps_to_cyc(T_WC_PS, CLK_PS));
   localparam int unsigned PW_CYC  = max_u(max_u(ps_to_cyc(T_WP_PS, CLK_PS),
                                                 ps_to_cyc(T_DW_PS, CLK_PS)),
                                           sub_floor(WIN_CYC, SU_CYC));
   localparam int unsigned REC_CYC = ps_to_cyc(T_HZ_PS, CLK_PS);
   localparam int unsigned MAX_DUR = max_u(max_u(RD_CYC, SU_CYC), max_u(PW_CYC, REC_CYC));
   localparam int unsigned CNT_W   = $clog2(MAX_DUR + 1);

   // elaboration-time parameter checks
   if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr_w
      $error("asram_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("asram_ctrl: DATA_W must be positive");
   end
   if (CLK_PS == 0) begin : g_bad_clk
      $error("asram_ctrl: CLK_PS must be positive");
   end
   if (MAX_DUR > 4096) begin : g_bad_dur
      $error("asram_ctrl: timing limits too long for the clock period");
   end

   seq_state_t nxt_state;
   logic       accept;
   logic       rd_last;
   logic       wr_last;

   asram_seq #(
      .RD_CYC  (RD_CYC),
      .SU_CYC  (SU_CYC),
      .PW_CYC  (PW_CYC),
      .REC_CYC (REC_CYC),
      .CNT_W   (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_we    (req_we),
      .req_ready (req_ready),
      .accept    (accept),
      .rd_last   (rd_last),
      .wr_last   (wr_last),
      .nxt_state (nxt_state)
   );

   asram_io #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_io (
      .clk         (clk),
      .rst_n       (rst_n),
      .nxt_state   (nxt_state),
      .accept      (accept),
      .rd_last     (rd_last),
      .wr_last     (wr_last),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .sram_dq_in  (sram_dq_in),
      .sram_addr   (sram_addr),
      .sram_ce_n   (sram_ce_n),
      .sram_we_n   (sram_we_n),
      .sram_oe_n   (sram_oe_n),
      .sram_dq_out (sram_dq_out),
      .sram_dq_oe  (sram_dq_oe),
      .rsp_done    (rsp_done),
      .rsp_rdata   (rsp_rdata)
   );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
   parameter int unsigned ADDR_W  = 15,
   parameter int unsigned RD_CYC  = 2,
   parameter int unsigned SU_CYC  = 1,
   parameter int unsigned PW_CYC  = 1,
   parameter int unsigned REC_CYC = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_done,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_ce_n,
   input logic              sram_we_n,
   input logic              sram_oe_n,
   input logic              sram_dq_oe
);

   localparam int unsigned SAT = 100000;

   int unsigned oe_lo_cnt;
   int unsigned we_lo_cnt;
   int unsigned ce_lo_cnt;
   int unsigned ce_hi_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_lo_cnt <= 0;
         we_lo_cnt <= 0;
         ce_lo_cnt <= 0;
         ce_hi_cnt <= REC_CYC + 1;
      end else begin
         oe_lo_cnt <= sram_oe_n ? 0 : oe_lo_cnt + 1;
         we_lo_cnt <= sram_we_n ? 0 : we_lo_cnt + 1;
         ce_lo_cnt <= sram_ce_n ? 0 : ce_lo_cnt + 1;
         if (!sram_ce_n)          ce_hi_cnt <= 0;
         else if (ce_hi_cnt < SAT) ce_hi_cnt <= ce_hi_cnt + 1;
      end
   end

   p_rd_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_oe_n) |-> (oe_lo_cnt == RD_CYC));

   p_rd_we_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> (sram_we_n && !sram_ce_n));

   p_we_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> !sram_ce_n);

   p_setup_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> (ce_lo_cnt == SU_CYC));

   p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (we_lo_cnt == PW_CYC));

   p_oe_high_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n || sram_dq_oe) |-> sram_oe_n);

   p_drive_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> !sram_we_n);

   p_pulse_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> sram_dq_oe);

   p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

   p_recover_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_ce_n) |-> (ce_hi_cnt >= REC_CYC + 1));

   p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

endmodule

bind asram_ctrl asram_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .RD_CYC  (RD_CYC),
   .SU_CYC  (SU_CYC),
   .PW_CYC  (PW_CYC),
   .REC_CYC (REC_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_done   (rsp_done),
   .sram_addr  (sram_addr),
   .sram_ce_n  (sram_ce_n),
   .sram_we_n  (sram_we_n),
   .sram_oe_n  (sram_oe_n),
   .sram_dq_oe (sram_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

   localparam int AW = 15;
   localparam int DW = 8;
   // expected phase lengths from the requirement formulas at 10 ns period
   localparam int TB_RD  = 2;  // max(ceil(12/10), ceil(12/10))
   localparam int TB_SU  = 1;  // ceil(0/10) floored to 1
   localparam int TB_PW  = 1;  // max(ceil(10/10), ceil(6/10), max(1,2)-1)
   localparam int TB_REC = 1;  // ceil(6/10)

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_done;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] sram_addr;
   logic          sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
   logic [DW-1:0] sram_dq_out;
   logic [DW-1:0] sram_dq_in;

   int n_checks = 0;
   int n_errors = 0;
   int n_clash  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   asram_ctrl u_asram_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
      .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
      .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
   );

   // behavioural RAM: 256 words, indexed by the low address byte
   logic [DW-1:0] mem [256];
   logic          ram_drv;
   initial for (int i = 0; i < 256; i++) mem[i] = '0;
   assign ram_drv    = !sram_ce_n && !sram_oe_n && sram_we_n;
   assign sram_dq_in = ram_drv ? mem[sram_addr[7:0]] : '0;
   always @(negedge clk) begin
      if (!sram_ce_n && !sram_we_n && sram_dq_oe) mem[sram_addr[7:0]] <= sram_dq_out;
      if (rst_n && ram_drv && sram_dq_oe) n_clash++;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(sram_ce_n && sram_we_n && sram_oe_n, "R1", "strobes in reset",
          {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
      chk(!sram_dq_oe && req_ready && !rsp_done, "R1", "oe/ready/done in reset",
          {sram_dq_oe, req_ready, rsp_done}, 3'b010);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sram_ce_n && req_ready && !rsp_done, "R1", "first cycle after reset",
          {sram_ce_n, req_ready, rsp_done}, 3'b110);
   endtask

   // at the done cycle (first recovery cycle) walk through recovery to ready
   task automatic t_recover(input string tag);
      chk(sram_ce_n && sram_we_n && sram_oe_n && !req_ready, "R6",
          {tag, " recovery strobes"}, {sram_ce_n, sram_we_n, sram_oe_n, req_ready}, 4'b1110);
      for (int k = 1; k < TB_REC; k++) begin
         @(negedge clk);
         chk(sram_ce_n && !req_ready, "R6", {tag, " recovery hold"},
             {sram_ce_n, req_ready}, 2'b10);
      end
      @(negedge clk);
      chk(req_ready, "R6", {tag, " ready after recovery"}, req_ready, 1);
      chk(!rsp_done, "R8", {tag, " done single cycle"}, rsp_done, 0);
   endtask

   task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < TB_SU; k++) begin
         chk(!sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R3", "write setup strobes",
             {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b0110);
         chk(sram_addr == a && !req_ready, "R5", "setup address", sram_addr, a);
         @(negedge clk);
      end
      for (int k = 0; k < TB_PW; k++) begin
         chk(!sram_ce_n && !sram_we_n && sram_dq_oe, "R3", "write pulse strobes",
             {sram_ce_n, sram_we_n, sram_dq_oe}, 3'b001);
         chk(sram_oe_n, "R4", "output enable high in write", sram_oe_n, 1);
         chk(sram_dq_out == d && sram_addr == a, "R5", "write data driven", sram_dq_out, d);
         @(negedge clk);
      end
      chk(rsp_done && !sram_dq_oe, "R8", "write done, driver released",
          {rsp_done, sram_dq_oe}, 2'b10);
      t_recover("write");
   endtask

   task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
      req_valid = 1'b1; req_we = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < TB_RD; k++) begin
         chk(!sram_ce_n && !sram_oe_n && sram_we_n && !sram_dq_oe, "R2", "read strobes",
             {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b0010);
         chk(!rsp_done && sram_addr == a, "R2", "read address", sram_addr, a);
         @(negedge clk);
      end
      chk(rsp_done, "R2", "read done", rsp_done, 1);
      chk(rsp_rdata == exp, "R2", "read data", rsp_rdata, exp);
      t_recover("read");
   endtask

   // request inputs change while busy; the access must not notice
   task automatic t_disturb(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [AW-1:0] ba, input logic [DW-1:0] bd);
      req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_we = 1'b0; req_addr = ba; req_wdata = bd;
      for (int k = 1; k < TB_SU; k++) @(negedge clk);
      @(negedge clk);
      for (int k = 0; k < TB_PW; k++) begin
         chk(sram_dq_out == d && sram_addr == a && !sram_we_n, "R7", "busy inputs ignored",
             {sram_addr, sram_dq_out}, {a, d});
         @(negedge clk);
      end
      chk(rsp_done && !req_ready, "R7", "no ready while busy", {rsp_done, req_ready}, 2'b10);
      for (int k = 1; k < TB_REC; k++) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready && sram_ce_n, "R7", "idle after disturbed write",
          {req_ready, sram_ce_n}, 2'b11);
      @(negedge clk);
      chk(sram_ce_n, "R7", "no access from dropped request", sram_ce_n, 1);
   endtask

   // read followed by a queued write: count high cycles of chip enable between them
   task automatic t_back_to_back(input logic [AW-1:0] ra, input logic [DW-1:0] rexp,
                                 input logic [AW-1:0] wa, input logic [DW-1:0] wd);
      int gap;
      req_valid = 1'b1; req_we = 1'b0; req_addr = ra;
      @(negedge clk);
      req_we = 1'b1; req_addr = wa; req_wdata = wd;
      for (int k = 1; k < TB_RD; k++) @(negedge clk);
      @(negedge clk);
      chk(rsp_done && rsp_rdata == rexp, "R2", "back-to-back read data", rsp_rdata, rexp);
      gap = 0;
      while (sram_ce_n && gap < 20) begin
         gap++;
         if (!req_ready) req_valid = 1'b1;
         @(negedge clk);
         if (!sram_ce_n) req_valid = 1'b0;
      end
      req_valid = 1'b0;
      chk(gap == TB_REC + 1, "R6", "chip enable high gap", gap, TB_REC + 1);
      for (int k = 1; k < TB_SU; k++) @(negedge clk);
      @(negedge clk);
      chk(!sram_we_n && sram_dq_out == wd, "R3", "queued write pulse", sram_dq_out, wd);
      for (int k = 1; k < TB_PW; k++) @(negedge clk);
      @(negedge clk);
      chk(rsp_done && rsp_rdata == rexp, "R8", "read data kept over write", rsp_rdata, rexp);
      t_recover("queued write");
   endtask

   initial begin
      t_reset();
      t_write(15'h0000, 8'hA5);
      t_write(15'h7FFF, 8'h5A);
      t_write(15'h1234, 8'h3C);
      t_read(15'h0000, 8'hA5);
      t_read(15'h7FFF, 8'h5A);
      t_read(15'h1234, 8'h3C);
      t_write(15'h0042, 8'h99);
      chk(rsp_rdata == 8'h3C, "R8", "read data unchanged by write", rsp_rdata, 8'h3C);
      t_disturb(15'h0010, 8'h11, 15'h0020, 8'hEE);
      t_read(15'h0010, 8'h11);
      t_read(15'h0020, 8'h00);
      t_back_to_back(15'h0042, 8'h99, 15'h0055, 8'h77);
      t_read(15'h0055, 8'h77);
      chk(n_clash == 0, "R4", "bus driven by both sides", n_clash, 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule